// File: doc/BRIEF.md
# Link Heartbeat Generator and Monitor

This per-port block keeps an Ethernet link alive and notices when the far end goes quiet. A slot-time tick (one pulse per 512 bit times) drives two counters. The transmit counter measures idle time since the last outgoing frame. When half of the programmed period passes with no transmit activity, the block emits a 60-byte MAC control frame on a byte stream. The frame carries a programmable source address and a programmable 16-bit opcode.

The receive counter measures time since the last good received frame. When the full period passes without one, the block raises a level interrupt. The interrupt stays high until software clears it. The receive counter starts again after each timeout, so a link that stays silent raises the interrupt once per period. A programmed period of zero turns both functions off. Frame check sequence generation and the MAC itself are outside this block.

Top module: `lnk_keepalive`

## Requirements
- R1: After reset, `frm_valid_o`, `frm_last_o` and `irq_o` are 0.
- R2: With period P > 1, let H = P >> 1. `frm_valid_o` rises in the cycle after the H-th slot tick that follows the last transmit restart. It stays 0 before that tick.
- R3: A `tx_activity_i` pulse restarts the idle count. A pulse in the same cycle as the H-th tick suppresses the heartbeat; H further ticks are then needed.
- R4: The frame is 60 bytes long, in this order:
  - bytes 0-5: 01 80 C2 00 00 01
  - bytes 6-11: `src_addr_i`, most significant byte first
  - bytes 12-13: 88 08
  - byte 14: `opcode_hi_i`; byte 15: `opcode_lo_i`
  - bytes 16-59: zero

  `frm_last_o` is 1 only on byte 59. A byte advances only when `frm_valid_o` and `frm_ready_i` are both 1; otherwise the byte and `frm_valid_o` hold.
- R5: The idle count is held at zero while a heartbeat frame is being sent. The next heartbeat comes H ticks after the last byte is accepted.
- R6: `irq_o` goes to 1 in the cycle after the P-th consecutive tick without `rx_good_i`. It stays 1 until an `irq_clear_i` pulse. If a timeout and a clear fall in the same cycle, `irq_o` is 1 afterwards.
- R7: `rx_good_i` restarts the receive count. A pulse in the same cycle as the P-th tick prevents the interrupt.
- R8: After a timeout the receive count restarts, so continued silence sets the interrupt again P ticks after the previous timeout.
- R9: P = 0 produces no heartbeat frame and no interrupt, however many ticks arrive.
- R10: For odd P, H rounds down, with a minimum of one tick: P = 5 gives H = 2, and P = 1 gives H = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_tick_i | input | 1 | One-cycle pulse per slot time |
| tx_activity_i | input | 1 | Pulse when an outgoing frame is sent |
| rx_good_i | input | 1 | Pulse when a good frame is received |
| period_i | input | 8 | Timeout period in slot times; 0 disables the block |
| opcode_hi_i | input | 8 | Heartbeat opcode, high byte |
| opcode_lo_i | input | 8 | Heartbeat opcode, low byte |
| src_addr_i | input | 48 | Source address placed in the frame |
| frm_data_o | output | 8 | Frame byte |
| frm_valid_o | output | 1 | Frame byte is valid |
| frm_last_o | output | 1 | Current byte is the final byte of the frame |
| frm_ready_i | input | 1 | Sink accepts the current byte |
| irq_o | output | 1 | Sticky receive-timeout interrupt |
| irq_clear_i | input | 1 | Clears the interrupt |

## Verification
Two pairs of events can land in the same cycle.

The receive timeout and an interrupt clear can coincide. The bench provokes this by raising `irq_clear_i` on exactly the P-th silent tick. It expects the interrupt to be high afterwards, because the set takes priority.

A restart pulse can also coincide with the final tick. The bench drives transmit activity, or a good receive, on the H-th or P-th tick. It expects neither a frame nor an interrupt, and expects the full count to be needed again.

Heartbeat bytes pass through a scoreboard while the sink stalls every third cycle.

// File: rtl/lhb_pkg.sv
package lhb_pkg;
  localparam int unsigned FRAME_BYTES = 60;
  localparam logic [47:0] CTRL_DST    = 48'h0180C2000001;
  localparam logic [15:0] CTRL_TYPE   = 16'h8808;
endpackage

// File: rtl/lhb_slot_timer.sv
module lhb_slot_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         restart_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         enabled;

  assign enabled  = |limit_i;
  // restart wins over a coinciding final tick
  assign expire_o = tick_i && enabled && !restart_i &&
                    (cnt_q >= limit_i - {{(W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (restart_i || !enabled)  cnt_q <= '0;
    else if (tick_i)                 cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
  end

  p_restart_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));
  p_expire_restarts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0));
endmodule

// File: rtl/lhb_frame_gen.sv
module lhb_frame_gen
  import lhb_pkg::*;
#(
  parameter int unsigned N_BYTES = FRAME_BYTES
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [47:0] src_i,
  input  logic [15:0] opcode_i,
  output logic [7:0]  data_o,
  output logic        valid_o,
  output logic        last_o,
  input  logic        ready_i
);
  localparam int unsigned IDX_W = $clog2(N_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BYTES - 1);

  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  int               pos;

  assign valid_o = busy_q;
  assign last_o  = busy_q && (idx_q == LAST_IDX);
  assign pos     = int'(idx_q);

  always_comb begin
    data_o = 8'h00;
    if (pos < 6)        data_o = CTRL_DST[8*(5-pos) +: 8];
    else if (pos < 12)  data_o = src_i[8*(11-pos) +: 8];
    else if (pos == 12) data_o = CTRL_TYPE[15:8];
    else if (pos == 13) data_o = CTRL_TYPE[7:0];
    else if (pos == 14) data_o = opcode_i[15:8];
    else if (pos == 15) data_o = opcode_i[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else if (ready_i) begin
      if (idx_q == LAST_IDX) busy_q <= 1'b0;
      else                   idx_q  <= idx_q + 1'b1;
    end
  end

  p_hold_on_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(idx_q)));
  p_end_after_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && last_o) |=> !valid_o);
endmodule

// File: rtl/lhb_irq_ctl.sv
module lhb_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clear_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_o <= 1'b0;
    else if (set_i)   irq_o <= 1'b1;  // set beats clear
    else if (clear_i) irq_o <= 1'b0;
  end

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clear_i) |=> irq_o);
  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> irq_o);
endmodule

// File: rtl/lnk_keepalive.sv
module lnk_keepalive
  import lhb_pkg::*;
#(
  parameter int unsigned PERIOD_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                slot_tick_i,
  input  logic                tx_activity_i,
  input  logic                rx_good_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [7:0]          opcode_hi_i,
  input  logic [7:0]          opcode_lo_i,
  input  logic [47:0]         src_addr_i,
  output logic [7:0]          frm_data_o,
  output logic                frm_valid_o,
  output logic                frm_last_o,
  input  logic                frm_ready_i,
  output logic                irq_o,
  input  logic                irq_clear_i
);
  logic [PERIOD_W-1:0] half, tx_limit;
  logic                tx_expire, rx_expire, tx_restart;

  assign half     = period_i >> 1;
  assign tx_limit = (period_i == '0) ? '0 :
                    (half == '0) ? {{(PERIOD_W-1){1'b0}}, 1'b1} : half;
  // the heartbeat itself counts as traffic: hold idle count while sending
  assign tx_restart = tx_activity_i || frm_valid_o;

  lhb_slot_timer #(.W(PERIOD_W)) i_tx_timer (
    .clk_i, .rst_ni, .tick_i(slot_tick_i), .restart_i(tx_restart),
    .limit_i(tx_limit), .expire_o(tx_expire)
  );

  lhb_slot_timer #(.W(PERIOD_W)) i_rx_timer (
    .clk_i, .rst_ni, .tick_i(slot_tick_i), .restart_i(rx_good_i),
    .limit_i(period_i), .expire_o(rx_expire)
  );

  lhb_frame_gen #(.N_BYTES(FRAME_BYTES)) i_frame (
    .clk_i, .rst_ni, .start_i(tx_expire), .src_i(src_addr_i),
    .opcode_i({opcode_hi_i, opcode_lo_i}), .data_o(frm_data_o),
    .valid_o(frm_valid_o), .last_o(frm_last_o), .ready_i(frm_ready_i)
  );

  lhb_irq_ctl i_irq (
    .clk_i, .rst_ni, .set_i(rx_expire), .clear_i(irq_clear_i), .irq_o
  );

  p_zero_no_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0 && !frm_valid_o) |=> !frm_valid_o);
  p_zero_no_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0 && !irq_o) |=> !irq_o);
  p_quiet_in_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_o |-> !tx_expire);
  p_activity_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_activity_i && !frm_valid_o) |=> !frm_valid_o);
endmodule

// File: tb/test_lnk_keepalive.sv
module test_lnk_keepalive;
  localparam int CLK_HALF = 5;
  localparam logic [47:0] SRC = 48'h021A2B3C4D5E;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, tx_act = 0, rx_good = 0, clr = 0, rdy = 0;
  logic [7:0] period = 8'd8, op_hi = 8'h00, op_lo = 8'h12;
  logic [7:0] data;
  logic valid, last, irq;

  int checks = 0, fails = 0, cyc = 0, rdy_cnt = 0;
  logic [8:0] sb_q[$];

  always #CLK_HALF clk = ~clk;

  lnk_keepalive i_lnk_keepalive (
    .clk_i(clk), .rst_ni(rst_n), .slot_tick_i(tick), .tx_activity_i(tx_act),
    .rx_good_i(rx_good), .period_i(period), .opcode_hi_i(op_hi),
    .opcode_lo_i(op_lo), .src_addr_i(SRC), .frm_data_o(data),
    .frm_valid_o(valid), .frm_last_o(last), .frm_ready_i(rdy),
    .irq_o(irq), .irq_clear_i(clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i);
    logic [47:0] dst = 48'h0180C2000001;
    if (i < 6)   return dst[8*(5-i) +: 8];
    if (i < 12)  return SRC[8*(11-i) +: 8];
    if (i == 12) return 8'h88;
    if (i == 13) return 8'h08;
    if (i == 14) return op_hi;
    if (i == 15) return op_lo;
    return 8'h00;
  endfunction

  task automatic push_frame();
    for (int i = 0; i < 60; i++) sb_q.push_back({(i == 59), exp_byte(i)});
  endtask

  // monitor: picks ready for the coming edge, then checks the byte offered
  always @(negedge clk) begin
    rdy_cnt++;
    rdy = (rdy_cnt % 3) != 0;
    if (valid && rdy) begin
      if (sb_q.size() == 0) chk(0, "R4 unexpected byte", int'(data), 0);
      else begin
        logic [8:0] e;
        e = sb_q.pop_front();
        chk({last, data} == e, "R4 frame byte", int'({last, data}), int'(e));
      end
    end
  end

  task automatic slot(input bit t, input bit r, input bit c);
    @(negedge clk); tick = 1; tx_act = t; rx_good = r; clr = c;
    @(negedge clk); tick = 0; tx_act = 0; rx_good = 0; clr = 0;
  endtask

  task automatic clear_irq();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic wait_done(input string req);
    while (valid) @(negedge clk);
    chk(sb_q.size() == 0, req, sb_q.size(), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!valid && !last && !irq, "R1 reset", {valid, last, irq}, 0);

    // R2: P=8, H=4
    repeat (3) slot(0, 1, 0);
    chk(!valid, "R2 early", valid, 0);
    push_frame();
    slot(0, 1, 0);
    chk(valid, "R2 start", valid, 1);
    wait_done("R4 frame complete");

    // R5: count restarts after the frame
    repeat (3) slot(0, 1, 0);
    chk(!valid, "R5 after frame early", valid, 0);
    push_frame();
    slot(0, 1, 0);
    chk(valid, "R5 next heartbeat", valid, 1);
    wait_done("R5 frame complete");

    // R3: activity restarts, including on the final tick
    repeat (3) slot(0, 1, 0);
    slot(1, 1, 0);
    chk(!valid, "R3 coincident activity", valid, 0);
    repeat (3) slot(0, 1, 0);
    chk(!valid, "R3 restarted count", valid, 0);
    push_frame();
    slot(0, 1, 0);
    chk(valid, "R3 heartbeat after restart", valid, 1);
    wait_done("R3 frame complete");

    // R10: odd periods
    op_hi = 8'hBE; op_lo = 8'hEF;
    period = 8'd5;
    slot(1, 1, 0);
    slot(0, 1, 0);
    chk(!valid, "R10 P=5 early", valid, 0);
    push_frame();
    slot(0, 1, 0);
    chk(valid, "R10 P=5 H=2", valid, 1);
    wait_done("R10 frame P=5");
    period = 8'd1;
    slot(1, 1, 0);
    push_frame();
    slot(0, 1, 0);
    chk(valid, "R10 P=1 H=1", valid, 1);
    wait_done("R10 frame P=1");

    // R9: disabled
    period = 8'd0;
    repeat (20) slot(0, 0, 0);
    chk(!valid && !irq, "R9 disabled", {valid, irq}, 0);

    // R6/R8: timeout, sticky, repeat
    period = 8'd6;
    slot(1, 1, 0);
    repeat (5) slot(1, 0, 0);
    chk(!irq, "R6 early", irq, 0);
    slot(1, 0, 0);
    chk(irq, "R6 timeout", irq, 1);
    repeat (3) slot(1, 0, 0);
    chk(irq, "R6 sticky", irq, 1);
    clear_irq();
    chk(!irq, "R6 clear", irq, 0);
    repeat (2) slot(1, 0, 0);
    chk(!irq, "R8 before period", irq, 0);
    slot(1, 0, 0);
    chk(irq, "R8 re-raise", irq, 1);
    clear_irq();

    // R7: good receive on the final tick
    slot(1, 1, 0);
    repeat (5) slot(1, 0, 0);
    slot(1, 1, 0);
    chk(!irq, "R7 coincident receive", irq, 0);
    repeat (5) slot(1, 0, 0);
    chk(!irq, "R7 restarted early", irq, 0);
    slot(1, 0, 0);
    chk(irq, "R7 timeout after restart", irq, 1);
    clear_irq();

    // R6: set and clear in one cycle
    slot(1, 1, 0);
    repeat (5) slot(1, 0, 0);
    slot(1, 0, 1);
    chk(irq, "R6 set beats clear", irq, 1);
    clear_irq();
    chk(!irq, "R6 final clear", irq, 0);
    chk(sb_q.size() == 0, "R4 scoreboard empty", sb_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule